// File: doc/BRIEF.md
# NAND Sequential Page Read Sequencer

This block is the device-side engine that runs after a read command has captured its address. A start pulse carries a row and a start column. The engine asks an array model to fill an internal page buffer and holds ready/busy low while the page is transferred. It then hands out one word per read strobe, from the start column up to the last column of the page.

A strobe that arrives after the last word has gone out does not return data. If chip-enable is still low at that strobe, it starts the transfer of the next row, and output resumes at column 0. Chaining only runs inside one block of 2**BLK_W pages. At the block end the engine goes idle and needs a new start. A mode input turns chaining off, and so does holding chip-enable high for too long.

The read side behaves like a valid/ready pair. `rd_avail` is the valid: it is high while the engine is streaming. `rd_strobe` is the ready: a word moves when both are high and `ce_n` is low. A strobe at any other time is dropped and does not stall or queue. The page fill from the array is a valid/ready stream, `fill_valid` / `fill_ready`. The array may hold a word for as long as `fill_ready` is low. The engine never drops a word that it has accepted.

Top module: `nand_seq_read`

## Requirements
- R1: After reset, `rdy_busy` is 1, `rd_avail` is 0, `rd_data` is 0 and `ld_req` is 0.
- R2: After a start pulse, `rdy_busy` goes low on the next cycle and stays low for exactly T_LOAD cycles, provided the array delivers the page within that time. `ld_row` equals the start row.
- R3: Each accepted strobe (`rd_strobe`, `ce_n` low, `rd_avail` high) places the next word on `rd_data` one cycle later. Words run from the start column, in rising column order, up to column 2**COL_W-1.
- R4: A strobe is ignored when the engine is busy, idle, or when `ce_n` is high. In those cases `rd_data` holds its value and the column does not advance.
- R5: A strobe after the last column, with `ce_n` low, loads row+1 whenever the low BLK_W row bits are not all ones. That strobe returns no word, busy lasts T_LOAD cycles again, and output then starts at column 0.
- R6: When the low BLK_W bits of the current row are all ones, a strobe after the last column sends the engine idle. `rd_avail` goes to 0, `rdy_busy` goes to 1, and no load is requested.
- R7: While streaming, `ce_n` sampled high on more than CE_HOLD consecutive edges ends the read, and `rd_avail` drops. Exactly CE_HOLD edges of high `ce_n` leave streaming intact.
- R8: While `seq_inhibit` is 1, a strobe after the last column sends the engine idle, as in R6, whatever the row.
- R9: `ld_req` stays high until it is sampled together with `ld_ack`. Only one request is made per page load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read command pulse; ignored while a page is loading |
| start_row | input | ROW_W | Row to read first |
| start_col | input | COL_W | First column to output |
| seq_inhibit | input | 1 | 1 disables chaining into the next page |
| ce_n | input | 1 | Chip enable, active low |
| rd_strobe | input | 1 | Read strobe (ready of the output stream) |
| rd_avail | output | 1 | Engine is streaming (valid of the output stream) |
| rd_data | output | DATA_W | Last word handed out |
| rdy_busy | output | 1 | 1 = ready, 0 = page transfer in progress |
| ld_req | output | 1 | Page load request to the array |
| ld_row | output | ROW_W | Row being loaded |
| ld_ack | input | 1 | Array accepts the load request |
| fill_valid | input | 1 | Array presents a page word |
| fill_data | input | DATA_W | Page word, in column order from 0 |
| fill_ready | output | 1 | Engine can take a page word |

## Verification
A start or chaining strobe that is sampled at edge k drops `rdy_busy` right after k. Ready returns T_LOAD edges later, so the bench counts falling edges with busy low and expects exactly T_LOAD of them. A word is due one cycle after its strobe edge. The bench drives each strobe on a falling edge, lowers it on the next falling edge and compares `rd_data` there. Termination by chip-enable is due on the (CE_HOLD+1)th high edge. The bench holds `ce_n` high for a counted number of edges and reads `rd_avail` on the falling edge that follows.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_LOAD   = 2'd1,
    RD_STREAM = 2'd2
  } rd_state_e;
endpackage

// File: rtl/nand_rd_loadtimer.sv
module nand_rd_loadtimer #(
  parameter int T_LOAD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(T_LOAD + 1);
  localparam logic [CW-1:0] LAST = CW'(T_LOAD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R2: the transfer time is only met after the engine has been loading
  p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && T_LOAD > 1) |-> $past(run));
endmodule

// File: rtl/nand_rd_pagebuf.sv
module nand_rd_pagebuf #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [COL_W-1:0]  rd_col,
  output logic              full,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << COL_W;

  logic [COL_W:0]      idx_q;
  logic [DATA_W-1:0]   mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clear)          idx_q <= '0;
    else if (wr_en && !full) idx_q <= idx_q + 1'b1;
  end

  assign full = (idx_q == (COL_W+1)'(DEPTH));

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && !full && idx_q[COL_W-1:0] == COL_W'(w))
        mem[w] <= wr_data;
    end
  end

  assign rd_word = mem[rd_col];

  // R2: the array never pushes a word into a complete page
  p_fill_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/nand_rd_ceguard.sv
module nand_rd_ceguard #(
  parameter int CE_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic expired
);
  localparam int HW = $clog2(CE_HOLD + 1);
  localparam logic [HW-1:0] LIM = HW'(CE_HOLD);

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_q <= '0;
    else if (!ce_n)      hi_q <= '0;
    else if (hi_q != LIM) hi_q <= hi_q + 1'b1;
  end

  assign expired = ce_n && (hi_q == LIM);

  // R7: expiry needs chip-enable to have been high on the edge before
  p_expire_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(ce_n));
endmodule

// File: rtl/nand_seq_read.sv
module nand_seq_read
  import nand_rd_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int BLK_W   = 5,
  parameter int T_LOAD  = 12,
  parameter int CE_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [COL_W-1:0]  start_col,
  input  logic              seq_inhibit,
  input  logic              ce_n,
  input  logic              rd_strobe,
  output logic              rd_avail,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy_busy,
  output logic              ld_req,
  output logic [ROW_W-1:0]  ld_row,
  input  logic              ld_ack,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_ready
);
  localparam int PAGE_WORDS = 1 << COL_W;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_WORDS - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = '1;
  localparam int LOW_W = $clog2(T_LOAD + 2);

  rd_state_e          state_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic               at_end_q;
  logic               req_q;
  logic               acked_q;
  logic [DATA_W-1:0]  data_q;

  logic               tmr_done;
  logic               buf_full;
  logic [DATA_W-1:0]  buf_word;
  logic               ce_expired;
  logic               loading;
  logic               take_cmd;
  logic               strobe_ok;
  logic               blk_end;

  assign loading   = (state_q == RD_LOAD);
  assign take_cmd  = start && !loading;
  assign strobe_ok = (state_q == RD_STREAM) && rd_strobe && !ce_n;
  assign blk_end   = (row_q[BLK_W-1:0] == BLK_LAST);

  nand_rd_loadtimer #(.T_LOAD(T_LOAD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (loading),
    .done (tmr_done)
  );

  nand_rd_pagebuf #(.DATA_W(DATA_W), .COL_W(COL_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!loading),
    .wr_en  (fill_valid && fill_ready),
    .wr_data(fill_data),
    .rd_col (col_q),
    .full   (buf_full),
    .rd_word(buf_word)
  );

  nand_rd_ceguard #(.CE_HOLD(CE_HOLD)) u_ce (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .expired(ce_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RD_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      at_end_q <= 1'b0;
      req_q    <= 1'b0;
      acked_q  <= 1'b0;
      data_q   <= '0;
    end else if (take_cmd) begin
      state_q  <= RD_LOAD;
      row_q    <= start_row;
      col_q    <= start_col;
      at_end_q <= 1'b0;
      req_q    <= 1'b1;
      acked_q  <= 1'b0;
    end else begin
      unique case (state_q)
        RD_LOAD: begin
          if (req_q && ld_ack) begin
            req_q   <= 1'b0;
            acked_q <= 1'b1;
          end
          if (tmr_done && buf_full) state_q <= RD_STREAM;
        end
        RD_STREAM: begin
          if (ce_expired) begin
            state_q <= RD_IDLE;
          end else if (strobe_ok) begin
            if (!at_end_q) begin
              data_q <= buf_word;
              if (col_q == LAST_COL) at_end_q <= 1'b1;
              else                   col_q    <= col_q + 1'b1;
            end else if (seq_inhibit || blk_end) begin
              state_q <= RD_IDLE;
            end else begin
              state_q  <= RD_LOAD;
              row_q    <= row_q + 1'b1;
              col_q    <= '0;
              at_end_q <= 1'b0;
              req_q    <= 1'b1;
              acked_q  <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_avail   = (state_q == RD_STREAM);
  assign rd_data    = data_q;
  assign rdy_busy   = !loading;
  assign ld_req     = req_q;
  assign ld_row     = row_q;
  assign fill_ready = loading && acked_q && !buf_full;

  // Consecutive busy cycles, kept for the busy-length property
  logic [LOW_W-1:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    low_cnt_q <= '0;
    else if (rdy_busy)             low_cnt_q <= '0;
    else if (low_cnt_q != '1)      low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R2: ready never returns before the full transfer time
  p_busy_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_busy) |-> (low_cnt_q >= LOW_W'(T_LOAD)));

  // R4: nothing is handed out while a page is loading
  p_busy_holds_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_busy |=> $stable(rd_data));

  // R3: the output word only moves after an accepted strobe
  p_data_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(rd_strobe && !ce_n && rd_avail));

  // R6: a chained load never wraps into the next block
  p_no_block_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ld_req) && !$past(start)) |-> (ld_row[BLK_W-1:0] != '0));

  // R8: chaining is not started while inhibited
  p_inhibit_blocks_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ld_req) && !$past(start)) |-> !$past(seq_inhibit));

  // R9: a request is held until the array takes it
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_ack) |=> ld_req);
endmodule

// File: tb/tb_nand_seq_read.sv
`timescale 1ns/1ps
module tb_nand_seq_read;
  localparam int ROW_W = 8, COL_W = 3, DATA_W = 8, BLK_W = 5;
  localparam int T_LOAD = 12, CE_HOLD = 4;
  localparam int PW = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ROW_W-1:0] start_row = '0;
  logic [COL_W-1:0] start_col = '0;
  logic seq_inhibit = 1'b0;
  logic ce_n = 1'b1;
  logic rd_strobe = 1'b0;
  logic rd_avail, rdy_busy, ld_req, fill_ready;
  logic [DATA_W-1:0] rd_data;
  logic [ROW_W-1:0] ld_row;
  logic ld_ack = 1'b0;
  logic fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nand_seq_read #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .T_LOAD(T_LOAD), .CE_HOLD(CE_HOLD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
    .start_col(start_col), .seq_inhibit(seq_inhibit), .ce_n(ce_n),
    .rd_strobe(rd_strobe), .rd_avail(rd_avail), .rd_data(rd_data),
    .rdy_busy(rdy_busy), .ld_req(ld_req), .ld_row(ld_row), .ld_ack(ld_ack),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready)
  );

  function automatic logic [DATA_W-1:0] word_of(input logic [ROW_W-1:0] r, input int c);
    return {r[4:0], 3'(c)};
  endfunction

  // Array model: acks after ack_delay falling edges, then streams the page
  int ack_delay = 0;
  int wait_cnt = 0;
  int fill_idx = 0;
  bit streaming = 1'b0;
  logic [ROW_W-1:0] mrow = '0;

  always @(negedge clk) begin
    if (ld_ack) begin
      ld_ack = 1'b0;
      mrow = ld_row;
      streaming = 1'b1;
      fill_idx = 0;
    end else if (ld_req) begin
      if (wait_cnt >= ack_delay) begin
        ld_ack = 1'b1;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
    if (streaming) begin
      if (fill_idx < PW) begin
        fill_valid = 1'b1;
        fill_data = word_of(mrow, fill_idx);
        fill_idx++;
      end else begin
        fill_valid = 1'b0;
        streaming = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    start = 1'b1; start_row = r; start_col = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_busy(output int nb, output int nr);
    nb = 0; nr = 0;
    while (!rdy_busy && nb < 100) begin
      nb++;
      if (ld_req) nr++;
      @(negedge clk);
    end
  endtask

  task automatic strobe();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // {row, start column, words to end of page}
  localparam logic [15:0] VECS [4] = '{
    {8'h00, 3'd0, 5'd8},
    {8'h25, 3'd3, 5'd5},
    {8'h41, 3'd7, 5'd1},
    {8'hFE, 3'd5, 5'd3}
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nb, nr;
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rdy_busy == 1'b1, "R1 rdy_busy", rdy_busy, 1);
    chk(rd_avail == 1'b0, "R1 rd_avail", rd_avail, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    chk(ld_req == 1'b0, "R1 ld_req", ld_req, 0);

    // R4: strobe while idle is ignored
    ce_n = 1'b0;
    strobe();
    chk(rd_data == '0, "R4 idle strobe", rd_data, 0);

    // R2/R3 vector walk
    for (int v = 0; v < 4; v++) begin
      logic [ROW_W-1:0] r;
      int c0, nw;
      r = VECS[v][15:8]; c0 = int'(VECS[v][7:5]); nw = int'(VECS[v][4:0]);
      do_start(r, 3'(c0));
      chk(ld_row == r, "R2 ld_row", ld_row, r);
      wait_busy(nb, nr);
      chk(nb == T_LOAD, "R2 busy length", nb, T_LOAD);
      for (int i = 0; i < nw; i++) begin
        strobe();
        chk(rd_data == word_of(r, c0 + i), "R3 word", rd_data, word_of(r, c0 + i));
      end
      chk(rd_avail == 1'b1, "R3 avail at page end", rd_avail, 1);
    end

    // R4: strobe during load ignored; R5 chain inside block
    do_start(8'h13, 3'd6);
    held = rd_data;
    strobe();
    chk(rd_data == held, "R4 busy strobe", rd_data, held);
    wait_busy(nb, nr);
    strobe();
    chk(rd_data == word_of(8'h13, 6), "R4 column not advanced", rd_data, word_of(8'h13, 6));
    strobe();
    chk(rd_data == word_of(8'h13, 7), "R3 last column", rd_data, word_of(8'h13, 7));
    strobe();
    chk(rdy_busy == 1'b0, "R5 chain busy", rdy_busy, 0);
    chk(ld_row == 8'h14, "R5 next row", ld_row, 8'h14);
    chk(rd_data == word_of(8'h13, 7), "R5 no word on chain strobe", rd_data, word_of(8'h13, 7));
    wait_busy(nb, nr);
    chk(nb == T_LOAD, "R5 chain busy length", nb, T_LOAD);
    strobe();
    chk(rd_data == word_of(8'h14, 0), "R5 column 0", rd_data, word_of(8'h14, 0));
    strobe();
    chk(rd_data == word_of(8'h14, 1), "R5 column 1", rd_data, word_of(8'h14, 1));

    // R6: block end stops chaining
    do_start(8'h3F, 3'd7);
    wait_busy(nb, nr);
    strobe();
    strobe();
    chk(rd_avail == 1'b0, "R6 avail", rd_avail, 0);
    chk(rdy_busy == 1'b1, "R6 ready", rdy_busy, 1);
    repeat (3) @(negedge clk);
    chk(ld_req == 1'b0, "R6 no request", ld_req, 0);

    // R7: chip-enable hold
    do_start(8'h02, 3'd0);
    wait_busy(nb, nr);
    strobe();
    ce_n = 1'b1;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    repeat (CE_HOLD - 1) @(negedge clk);
    ce_n = 1'b0;
    chk(rd_avail == 1'b1, "R7 short hold keeps stream", rd_avail, 1);
    chk(rd_data == word_of(8'h02, 0), "R4 strobe with ce high", rd_data, word_of(8'h02, 0));
    strobe();
    chk(rd_data == word_of(8'h02, 1), "R7 resume column", rd_data, word_of(8'h02, 1));
    ce_n = 1'b1;
    repeat (CE_HOLD + 1) @(negedge clk);
    ce_n = 1'b0;
    chk(rd_avail == 1'b0, "R7 long hold ends read", rd_avail, 0);

    // R8: inhibit chaining
    seq_inhibit = 1'b1;
    do_start(8'h04, 3'd7);
    wait_busy(nb, nr);
    strobe();
    strobe();
    chk(rd_avail == 1'b0, "R8 inhibited stop", rd_avail, 0);
    repeat (2) @(negedge clk);
    chk(ld_req == 1'b0, "R8 no request", ld_req, 0);
    seq_inhibit = 1'b0;

    // R9: request held across slow acknowledge
    ack_delay = 2;
    do_start(8'h30, 3'd0);
    wait_busy(nb, nr);
    chk(nr == 3, "R9 request held", nr, 3);
    chk(nb == T_LOAD, "R9 busy length", nb, T_LOAD);
    strobe();
    chk(rd_data == word_of(8'h30, 0), "R9 data after slow ack", rd_data, word_of(8'h30, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule